// File: doc/BRIEF.md
# SD/MMC Card Identification Sequencer

This block runs the identification phase of a host controller on a single-bit SD/MMC command line. After a `start` pulse it walks the card population: it asks the cards for their operating conditions, retries while they report that they are not ready, then loops over "all send CID" (CMD2) and "relative address" (CMD3) until no card answers or its address table is full. Each relative card address (RCA) obtained along the way is stored and can be read back by index.

The two card families take different paths. In SD mode the condition query is an application command, CMD55 followed by CMD41. The command driver stays push-pull and the card publishes its own RCA in the CMD3 response. In MMC mode the query is CMD1 and the driver runs open-drain. The host hands out RCAs itself, counting up from 1. Framing, CRC and serialisation sit outside the block. Each command leaves as an index and an argument on a request line. The answer comes back as one acknowledge cycle that carries a payload and a timeout flag. While a sequence runs the block also selects the slow identification clock.

Top module: `sdmmc_ident_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `cmd_req`, `clk_slow`, `drv_open_drain`, `done` and `err` are 0, and `card_count` is 0.
- R2: `clk_slow` is 1 on every cycle that a sequence runs (`busy`=1), including every cycle with `cmd_req`=1. It returns to 0 once the sequence ends.
- R3: `drv_open_drain` is 1 while an MMC sequence runs. It is 0 throughout an SD sequence and when idle.
- R4: The first command of an SD sequence is index 55 with argument 0, and each index 41 command follows an index 55. The first command of an MMC sequence is index 1. Both condition commands (41 and 1) carry argument 0x00FF8000.
- R5: A condition response with bit 31 clear is retried, repeating both CMD55 and CMD41 in SD mode. A retry happens only while fewer than `retry_limit` retries have been made. Past that limit the block raises `err`, ends without issuing CMD2, and does not pulse `done`.
- R6: A timeout on CMD55 or on the condition command ends the sequence with `err`=1 and no further command.
- R7: After a ready condition response, CMD2 (argument 0) is followed by CMD3 for each card that answers. A CMD2 timeout ends the loop with a single-cycle `done` pulse and `err`=0.
- R8: In MMC mode the n-th CMD3 of a sequence (n from 1) carries argument n in bits 31:16 and zeros in bits 15:0, and n is stored as that card's RCA.
- R9: In SD mode CMD3 carries argument 0, and bits 31:16 of its response are stored as the card's RCA.
- R10: In SD mode with `sd_reissue`=1, each card gets two CMD3 commands and the RCA from the second response is the one kept. The card count rises by one per card.
- R11: The table holds MAX_CARDS (4) entries. After the MAX_CARDS-th RCA is stored the block pulses `done` without issuing another CMD2, and `card_count` never exceeds MAX_CARDS.
- R12: `rd_rca` shows the table entry selected by `rd_sel`. Entries 0 to `card_count`-1 hold the RCAs in the order the cards were identified.
- R13: Once `cmd_req` rises, it stays 1 with `cmd_idx` and `cmd_arg` unchanged until the cycle in which `cmd_ack` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (sampled while idle) |
| mmc_mode | input | 1 | 1 = MMC flow, 0 = SD flow (latched at start) |
| sd_reissue | input | 1 | SD only: send CMD3 twice per card (latched at start) |
| retry_limit | input | RETRY_W | Retries allowed for a not-ready condition response |
| cmd_req | output | 1 | Command request |
| cmd_idx | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_ack | input | 1 | Response or timeout for the pending command, one cycle |
| rsp_data | input | 32 | Response payload, valid with cmd_ack |
| rsp_timeout | input | 1 | No response arrived, valid with cmd_ack |
| busy | output | 1 | Sequence in progress |
| clk_slow | output | 1 | Select identification-rate card clock (below 400 kHz) |
| drv_open_drain | output | 1 | 1 = open-drain command driver, 0 = push-pull |
| done | output | 1 | One-cycle pulse on normal end of the loop |
| err | output | 1 | Sequence aborted; held until the next start |
| card_count | output | CW | Number of cards identified |
| rd_sel | input | SW | Table read index |
| rd_rca | output | 16 | RCA stored at rd_sel |

## Verification
A responder models a population of 0 to 5 cards, each with its own RCA. The cards answer "not ready" for 0 to 2 condition attempts, and the retry limit is 1. Every combination runs in both modes and with and without CMD3 reissue. This covers the empty population, one card below the table size, exactly the table size and overflow, so an off-by-one in the loop exit or the table-full stop shows up in the command counts. The 2-attempt delay against a limit of 1 separates a limit counted as retries from one counted as attempts. The reissue runs give each CMD3 response of a card a different RCA, which shows whether the first or the last one was kept. Separate runs with a CMD55 timeout and a CMD1 timeout exercise the error exits.

// File: rtl/sdmmc_ident_seq.sv
module sdmmc_ident_seq #(
  parameter int MAX_CARDS = 4,
  parameter int RETRY_W = 4,
  localparam int CW = $clog2(MAX_CARDS + 1),
  localparam int SW = (MAX_CARDS > 1) ? $clog2(MAX_CARDS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               mmc_mode,
  input  logic               sd_reissue,
  input  logic [RETRY_W-1:0] retry_limit,
  output logic               cmd_req,
  output logic [5:0]         cmd_idx,
  output logic [31:0]        cmd_arg,
  input  logic               cmd_ack,
  input  logic [31:0]        rsp_data,
  input  logic               rsp_timeout,
  output logic               busy,
  output logic               clk_slow,
  output logic               drv_open_drain,
  output logic               done,
  output logic               err,
  output logic [CW-1:0]      card_count,
  input  logic [SW-1:0]      rd_sel,
  output logic [15:0]        rd_rca
);
  localparam logic [31:0] COND_ARG = 32'h00FF8000;

  typedef enum logic [2:0] {S_IDLE, S_APP, S_COND, S_CID, S_RCA} st_t;

  st_t               st;
  logic              mmc, reissue, rep;
  logic [RETRY_W-1:0] limit, tries;
  logic [CW-1:0]     cnt;
  logic [15:0]       tbl [MAX_CARDS];
  logic [15:0]       next_rca, new_rca;

  assign next_rca       = 16'(cnt) + 16'd1;
  assign new_rca        = mmc ? next_rca : rsp_data[31:16];
  assign busy           = (st != S_IDLE);
  assign cmd_req        = busy;
  assign clk_slow       = busy;
  assign drv_open_drain = busy && mmc;
  assign card_count     = cnt;
  assign rd_rca         = tbl[rd_sel];

  always_comb begin
    cmd_idx = 6'd0;
    cmd_arg = 32'd0;
    case (st)
      S_APP:  cmd_idx = 6'd55;
      S_COND: begin cmd_idx = mmc ? 6'd1 : 6'd41; cmd_arg = COND_ARG; end
      S_CID:  cmd_idx = 6'd2;
      S_RCA:  begin cmd_idx = 6'd3; cmd_arg = mmc ? {next_rca, 16'h0} : 32'd0; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      mmc <= 1'b0;
      reissue <= 1'b0;
      rep <= 1'b0;
      limit <= '0;
      tries <= '0;
      cnt <= '0;
      done <= 1'b0;
      err <= 1'b0;
      for (int i = 0; i < MAX_CARDS; i++) tbl[i] <= 16'h0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          mmc <= mmc_mode;
          reissue <= sd_reissue;
          limit <= retry_limit;
          tries <= '0;
          cnt <= '0;
          err <= 1'b0;
          rep <= 1'b0;
          st <= mmc_mode ? S_COND : S_APP;
        end
        S_APP: if (cmd_ack) begin
          if (rsp_timeout) begin err <= 1'b1; st <= S_IDLE; end
          else st <= S_COND;
        end
        S_COND: if (cmd_ack) begin
          if (rsp_timeout) begin err <= 1'b1; st <= S_IDLE; end
          else if (rsp_data[31]) st <= S_CID;
          else if (tries == limit) begin err <= 1'b1; st <= S_IDLE; end
          else begin
            tries <= tries + 1'b1;
            st <= mmc ? S_COND : S_APP;
          end
        end
        S_CID: if (cmd_ack) begin
          if (rsp_timeout) begin done <= 1'b1; st <= S_IDLE; end
          else begin rep <= 1'b0; st <= S_RCA; end
        end
        S_RCA: if (cmd_ack) begin
          if (rsp_timeout) begin err <= 1'b1; st <= S_IDLE; end
          else begin
            tbl[cnt[SW-1:0]] <= new_rca;
            if (!mmc && reissue && !rep) rep <= 1'b1;
            else begin
              cnt <= cnt + 1'b1;
              if (cnt == CW'(MAX_CARDS - 1)) begin done <= 1'b1; st <= S_IDLE; end
              else st <= S_CID;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdmmc_ident_seq_chk.sv
module sdmmc_ident_seq_chk #(
  parameter int MAX_CARDS = 4,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_req,
  input logic          cmd_ack,
  input logic [5:0]    cmd_idx,
  input logic [31:0]   cmd_arg,
  input logic          busy,
  input logic          clk_slow,
  input logic          drv_open_drain,
  input logic          done,
  input logic          err,
  input logic [CW-1:0] card_count
);
  // R13
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_idx) && $stable(cmd_arg)));
  // R2
  slow_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |-> clk_slow);
  // R3
  od_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_open_drain |-> busy);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  done_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!err && !busy));
  // R11
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_count <= CW'(MAX_CARDS));
endmodule

bind sdmmc_ident_seq sdmmc_ident_seq_chk #(.MAX_CARDS(MAX_CARDS), .CW(CW)) chk (
  .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req), .cmd_ack(cmd_ack),
  .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .busy(busy), .clk_slow(clk_slow),
  .drv_open_drain(drv_open_drain), .done(done), .err(err), .card_count(card_count)
);

// File: tb/sdmmc_ident_seq_test.sv
module sdmmc_ident_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAXC = 4;

  logic clk = 0, rst_n = 0, start = 0, mmc_mode = 0, sd_reissue = 0;
  logic [3:0] retry_limit = 0;
  logic cmd_req, cmd_ack = 0, rsp_timeout = 0;
  logic [5:0] cmd_idx;
  logic [31:0] cmd_arg, rsp_data = 0;
  logic busy, clk_slow, drv_open_drain, done, err;
  logic [2:0] card_count;
  logic [1:0] rd_sel = 0;
  logic [15:0] rd_rca;

  int total = 0, bad = 0;
  int ncards, bdelay, served, phase3, n55, ncond, n2, n3, ndone, nfirst;
  bit t55, tcond, cur_mmc;
  int last_idx;

  sdmmc_ident_seq uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int sdrca(input int k, input int p);
    return 16'h1200 + k * 16'h0100 + p;
  endfunction

  always @(negedge clk) begin
    if (done) ndone++;
    if (cmd_ack) begin
      cmd_ack = 0;
      rsp_timeout = 0;
      rsp_data = 0;
    end else if (cmd_req) begin
      chk(clk_slow == 1, "R2 clk_slow during command", clk_slow, 1);
      chk(drv_open_drain == cur_mmc, "R3 driver mode", drv_open_drain, cur_mmc);
      if (nfirst == 0)
        chk(cmd_idx == (cur_mmc ? 1 : 55), "R4 first command", cmd_idx, cur_mmc ? 1 : 55);
      nfirst++;
      rsp_timeout = 0;
      rsp_data = 0;
      case (cmd_idx)
        55: begin
          n55++;
          chk(cmd_arg == 0, "R4 CMD55 arg", cmd_arg, 0);
          rsp_timeout = t55;
        end
        41, 1: begin
          ncond++;
          chk(cmd_idx == (cur_mmc ? 1 : 41), "R4 condition index", cmd_idx, cur_mmc ? 1 : 41);
          if (!cur_mmc) chk(last_idx == 55, "R4 CMD41 after CMD55", last_idx, 55);
          chk(cmd_arg == 32'h00FF8000, "R4 condition arg", cmd_arg, 32'h00FF8000);
          rsp_timeout = tcond;
          rsp_data = (ncond > bdelay) ? 32'h80FF8000 : 32'h00FF8000;
        end
        2: begin
          n2++;
          chk(cmd_arg == 0, "R7 CMD2 arg", cmd_arg, 0);
          phase3 = 0;
          if (served < ncards) served++;
          else rsp_timeout = 1;
        end
        3: begin
          n3++;
          phase3++;
          if (cur_mmc) chk(cmd_arg == {16'(served), 16'h0}, "R8 MMC CMD3 arg", cmd_arg, {16'(served), 16'h0});
          else chk(cmd_arg == 0, "R9 SD CMD3 arg", cmd_arg, 0);
          rsp_data = {16'(sdrca(served - 1, phase3)), 16'h0};
        end
        default: chk(0, "R4 unexpected index", cmd_idx, 0);
      endcase
      last_idx = cmd_idx;
      cmd_ack = 1;
    end
  end

  task automatic run(input bit m, input int nc, input int bd, input int rl,
                     input bit rei, input bit e55, input bit econd);
    int cnt_e, n2_e, n3_e, nc_e, n55_e, w;
    bit err_e;
    string tg;
    cur_mmc = m; ncards = nc; bdelay = bd; t55 = e55; tcond = econd;
    served = 0; phase3 = 0; n55 = 0; ncond = 0; n2 = 0; n3 = 0; ndone = 0; nfirst = 0; last_idx = 0;
    @(negedge clk);
    mmc_mode = m; sd_reissue = rei; retry_limit = 4'(rl); start = 1;
    @(negedge clk);
    start = 0;
    w = 0;
    while (busy && w < 3000) begin @(negedge clk); w++; end
    @(negedge clk);
    err_e = e55 || econd || (bd > rl);
    if (e55) begin n55_e = 1; nc_e = 0; end
    else begin
      nc_e = econd ? 1 : ((bd > rl) ? rl + 1 : bd + 1);
      n55_e = m ? 0 : nc_e;
    end
    cnt_e = err_e ? 0 : ((nc < MAXC) ? nc : MAXC);
    n2_e = err_e ? 0 : ((nc < MAXC) ? nc + 1 : MAXC);
    n3_e = cnt_e * ((rei && !m) ? 2 : 1);
    tg = $sformatf("m=%0d nc=%0d bd=%0d rei=%0d t55=%0d tc=%0d", m, nc, bd, rei, e55, econd);
    chk(err == err_e, {"R5 R6 err ", tg}, err, err_e);
    chk(ndone == (err_e ? 0 : 1), {"R7 done pulses ", tg}, ndone, err_e ? 0 : 1);
    chk(n55 == n55_e, {"R5 CMD55 count ", tg}, n55, n55_e);
    chk(ncond == nc_e, {"R5 condition count ", tg}, ncond, nc_e);
    chk(n2 == n2_e, {"R11 CMD2 count ", tg}, n2, n2_e);
    chk(n3 == n3_e, {"R10 CMD3 count ", tg}, n3, n3_e);
    chk(card_count == cnt_e, {"R11 card_count ", tg}, card_count, cnt_e);
    chk(!clk_slow && !drv_open_drain && !busy, {"R2 R3 idle outputs ", tg}, {clk_slow, drv_open_drain}, 0);
    for (int i = 0; i < cnt_e; i++) begin
      int exp;
      exp = m ? i + 1 : sdrca(i, rei ? 2 : 1);
      rd_sel = 2'(i);
      #1;
      chk(rd_rca == 16'(exp), {"R12 R8 R9 R10 rca ", tg}, rd_rca, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    chk(!busy && !cmd_req && !clk_slow && !drv_open_drain && !done && !err && card_count == 0,
        "R1 reset state", {busy, cmd_req, clk_slow, drv_open_drain, done, err}, 0);
    rst_n = 1;
    for (int m = 0; m < 2; m++)
      for (int nc = 0; nc < 6; nc++)
        for (int bd = 0; bd < 3; bd++)
          for (int rei = 0; rei < 2; rei++)
            run(m[0], nc, bd, 1, rei[0], 0, 0);
    run(0, 2, 0, 1, 0, 1, 0);
    run(1, 2, 0, 1, 0, 0, 1);
    run(0, 3, 0, 0, 1, 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule